// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a linear address into a physical address by reading two levels of translation entries from memory. The first read picks an entry from the top-level directory, whose page is named by a root base input. That entry points to a second-level table, and the second read picks the final entry, which gives the page frame. The frame number is joined with the untranslated page offset to form the result. Each request also carries an access kind (read or write) and a privilege level from 0 to 3. The walker checks the permission bits of both entries together and reports either the physical address or a fault with a cause code.

On a successful walk the walker keeps the usage bits of the entries up to date. It marks both entries as accessed. On a write it also marks the second-level entry as modified. It writes an entry back only if one of these bits actually changes. Two mode inputs control the rest of the behaviour. With translation disabled, the request is answered at once with the linear address. With translation enabled but protection disabled, the request is refused as a mode error. All other entry bits, including the cache-attribute bits, are left untouched when an entry is written back.

The memory port issues one access at a time. A read is a one-cycle `memRdEn` pulse, and the data comes back on a later cycle, marked by `memRvalid`. A write is a one-cycle `memWrEn` pulse and is taken as accepted in that cycle.

Top module: `page_walker`

## Requirements
- R1: The linear address splits as directory index = bits 31:22, table index = bits 21:12 and offset = bits 11:0. The directory entry is read at {root[31:12], directory index, 2'b00}. The table entry is read at {directory entry[31:12], table index, 2'b00}. The physical address is {table entry[31:12], offset}. Example: root 0x00005000 and linear 0x00801050 give a directory entry read at 0x00005008 (value 0x08001001) and a table entry read at 0x08001004 (value 0x0000C001), for a result of 0x0000C050.
- R2: Entry bit 0 is the presence bit. If the directory entry has bit 0 clear, the walk faults with code 0 after exactly one memory read. If the table entry has bit 0 clear, the walk faults with code 0 after two reads.
- R3: Entry bit 2 is the user-access bit. A request at privilege 3 faults with code 1 when bit 2 is clear in either entry. Privilege levels 0, 1 and 2 are never refused on this bit.
- R4: Entry bit 1 is the write-enable bit. A write at privilege 3 faults with code 2 when bit 1 is clear in either entry. A write at privilege 0 to 2 ignores bit 1. When both the code 1 and the code 2 conditions hold, the code reported is 1.
- R5: After a successful walk, bit 5 (accessed) is set in both entries in memory. After a successful write, bit 6 (modified) is also set in the table entry. Bit 6 of the directory entry is never changed.
- R6: An entry is written back only when its bit 5 or bit 6 would change. Faulting walks write nothing. A write-back preserves every other bit of the entry, for example bits 3 and 4.
- R7: With `pagingEn` low, the result is the linear address unchanged, with no fault and no memory access.
- R8: With `pagingEn` high and `protEn` low, the request faults with code 3 and makes no memory access.
- R9: Each accepted request produces exactly one one-cycle `done` pulse. `fault`, `faultCode` and `physAddr` are valid while `done` is high. `busy` is high from the cycle after acceptance until `done` has been given.
- R10: After reset the walker is idle, with `done`, `busy`, `memRdEn` and `memWrEn` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqAddr | input | 32 | Linear address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqPriv | input | 2 | Privilege level of the access (3 = least privileged) |
| rootBase | input | 32 | Physical base of the directory page (bits 31:12 used) |
| pagingEn | input | 1 | Translation enable |
| protEn | input | 1 | Protection mode enable; required when translation is on |
| memRdEn | output | 1 | Entry read strobe |
| memWrEn | output | 1 | Entry write-back strobe |
| memAddr | output | 32 | Entry address for read or write |
| memWdata | output | 32 | Entry value to write back |
| memRdata | input | 32 | Entry value returned by memory |
| memRvalid | input | 1 | Read data valid |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed (valid with done) |
| faultCode | output | 2 | 0 absent, 1 privilege, 2 write, 3 mode (valid with done and fault) |
| physAddr | output | 32 | Translated address (valid with done, no fault) |
| busy | output | 1 | Walk in progress |

## Verification
The bench builds the walker with its default index width of 10 bits, which gives the 32-bit layout. This makes the worked example above reachable exactly. It also reaches the last directory slot at 0x5FFC and the full 0xFFF offset. A one-cycle-latency memory model counts every read and write and keeps the entry values, so the port can show how many reads a walk made, whether a write-back happened, and which bits it changed.

// File: rtl/pw_pkg.sv
package pw_pkg;

  // Entry bit positions; the walk depends on these exact slots.
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  localparam int LEVELS = 2;

  typedef enum logic [1:0] {
    FC_ABSENT = 2'd0,
    FC_PRIV   = 2'd1,
    FC_WRITE  = 2'd2,
    FC_MODE   = 2'd3
  } faultCode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DIR_REQ,
    S_DIR_WAIT,
    S_TBL_REQ,
    S_TBL_WAIT,
    S_CHECK,
    S_WB_DIR,
    S_WB_TBL,
    S_DONE,
    S_FAULT
  } walkState_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic takeReq;
    logic rdDir;
    logic rdTbl;
    logic grabDir;
    logic grabTbl;
    logic wrDir;
    logic wrTbl;
  } walkStb_t;

  // Datapath -> control status
  typedef struct packed {
    logic rdPresent;   // presence bit of the word now on the read bus
    logic dirPresent;  // presence bit of the captured directory entry
    logic tblPresent;  // presence bit of the captured table entry
    logic privDeny;
    logic writeDeny;
    logic dirStale;    // directory entry needs a write-back
    logic tblStale;    // table entry needs a write-back
  } walkSts_t;

endpackage

// File: rtl/pw_perm.sv
module pw_perm
  import pw_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] dirEntry,
  input  logic [ENTRY_W-1:0] tblEntry,
  input  logic               isWrite,
  input  logic [1:0]         priv,
  output logic               privDeny,
  output logic               writeDeny,
  output logic               dirStale,
  output logic               tblStale,
  output logic [ENTRY_W-1:0] dirNext,
  output logic [ENTRY_W-1:0] tblNext
);

  logic [ENTRY_W-1:0] levelEntry [LEVELS];
  logic [LEVELS-1:0]  userOk;
  logic [LEVELS-1:0]  writeOk;
  logic               isUser;

  assign levelEntry[0] = dirEntry;
  assign levelEntry[1] = tblEntry;
  assign isUser        = (priv == 2'd3);

  // Each level grants independently; the access needs every level's grant.
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    assign userOk[lv]  = levelEntry[lv][BIT_US];
    assign writeOk[lv] = levelEntry[lv][BIT_RW];
  end

  assign privDeny  = isUser && !(&userOk);
  assign writeDeny = isUser && isWrite && !(&writeOk);

  always_comb begin
    dirNext        = dirEntry;
    dirNext[BIT_A] = 1'b1;
    tblNext        = tblEntry;
    tblNext[BIT_A] = 1'b1;
    if (isWrite) tblNext[BIT_D] = 1'b1;
  end

  assign dirStale = !dirEntry[BIT_A];
  assign tblStale = !tblEntry[BIT_A] || (isWrite && !tblEntry[BIT_D]);

endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter  int IDX_W  = 10,
  localparam int OFF_W  = IDX_W + 2,
  localparam int ADDR_W = 2 * IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStb_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqPriv,
  input  logic              pagingEn,
  input  logic [ADDR_W-1:0] rootBase,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] physAddr,
  output walkSts_t          sts
);

  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] linQ, rootQ, dirQ, tblQ;
  logic              wrQ, bypassQ;
  logic [1:0]        privQ;

  logic [IDX_W-1:0]  dirIdx, tblIdx;
  logic [ADDR_W-1:0] dirAddr, tblAddr;
  logic [ADDR_W-1:0] dirNext, tblNext;
  logic              privDeny, writeDeny, dirStale, tblStale;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linQ    <= '0;
      rootQ   <= '0;
      wrQ     <= 1'b0;
      privQ   <= '0;
      bypassQ <= 1'b0;
    end else if (stb.takeReq) begin
      linQ    <= reqAddr;
      rootQ   <= rootBase;
      wrQ     <= reqWrite;
      privQ   <= reqPriv;
      bypassQ <= !pagingEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      tblQ <= '0;
    end else begin
      if (stb.takeReq) begin
        dirQ <= '0;
        tblQ <= '0;
      end
      if (stb.grabDir) dirQ <= memRdata;
      if (stb.grabTbl) tblQ <= memRdata;
    end
  end

  assign dirIdx  = linQ[ADDR_W-1 -: IDX_W];
  assign tblIdx  = linQ[OFF_W +: IDX_W];
  assign dirAddr = {rootQ[ADDR_W-1 -: FRAME_W], dirIdx, 2'b00};
  assign tblAddr = {dirQ[ADDR_W-1 -: FRAME_W], tblIdx, 2'b00};

  pw_perm #(.ENTRY_W(ADDR_W)) i_perm (
    .dirEntry (dirQ),
    .tblEntry (tblQ),
    .isWrite  (wrQ),
    .priv     (privQ),
    .privDeny (privDeny),
    .writeDeny(writeDeny),
    .dirStale (dirStale),
    .tblStale (tblStale),
    .dirNext  (dirNext),
    .tblNext  (tblNext)
  );

  always_comb begin
    if (stb.rdDir || stb.wrDir) memAddr = dirAddr;
    else                        memAddr = tblAddr;
  end

  assign memWdata = stb.wrDir ? dirNext : tblNext;
  assign physAddr = bypassQ ? linQ : {tblQ[ADDR_W-1 -: FRAME_W], linQ[OFF_W-1:0]};

  assign sts.rdPresent  = memRdata[BIT_P];
  assign sts.dirPresent = dirQ[BIT_P];
  assign sts.tblPresent = tblQ[BIT_P];
  assign sts.privDeny   = privDeny;
  assign sts.writeDeny  = writeDeny;
  assign sts.dirStale   = dirStale;
  assign sts.tblStale   = tblStale;

  // R5: the directory write-back never alters its modified bit
  a_r5_dir_dirty_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDir |-> (memWdata[BIT_D] == dirQ[BIT_D]) && memWdata[BIT_A]);

  // R1: the table read is aimed inside the frame the directory entry names
  a_r1_tbl_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdTbl |-> (memAddr[ADDR_W-1 -: FRAME_W] == dirQ[ADDR_W-1 -: FRAME_W]));

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pagingEn,
  input  logic       protEn,
  input  logic       memRvalid,
  input  walkSts_t   sts,
  output walkStb_t   stb,
  output logic       memRdEn,
  output logic       memWrEn,
  output logic       done,
  output logic       fault,
  output logic [1:0] faultCode,
  output logic       busy
);

  walkState_e st, stNext;
  faultCode_e codeQ, codeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      codeQ <= FC_ABSENT;
    end else begin
      st    <= stNext;
      codeQ <= codeNext;
    end
  end

  always_comb begin
    stNext   = st;
    codeNext = codeQ;
    stb      = '0;
    unique case (st)
      S_IDLE: begin
        if (reqValid) begin
          stb.takeReq = 1'b1;
          if (!pagingEn) begin
            stNext = S_DONE;
          end else if (!protEn) begin
            stNext   = S_FAULT;
            codeNext = FC_MODE;
          end else begin
            stNext = S_DIR_REQ;
          end
        end
      end
      S_DIR_REQ: begin
        stb.rdDir = 1'b1;
        stNext    = S_DIR_WAIT;
      end
      S_DIR_WAIT: begin
        if (memRvalid) begin
          stb.grabDir = 1'b1;
          if (!sts.rdPresent) begin
            stNext   = S_FAULT;
            codeNext = FC_ABSENT;
          end else begin
            stNext = S_TBL_REQ;
          end
        end
      end
      S_TBL_REQ: begin
        stb.rdTbl = 1'b1;
        stNext    = S_TBL_WAIT;
      end
      S_TBL_WAIT: begin
        if (memRvalid) begin
          stb.grabTbl = 1'b1;
          stNext      = S_CHECK;
        end
      end
      S_CHECK: begin
        if (!sts.tblPresent) begin
          stNext   = S_FAULT;
          codeNext = FC_ABSENT;
        end else if (sts.privDeny) begin
          stNext   = S_FAULT;
          codeNext = FC_PRIV;
        end else if (sts.writeDeny) begin
          stNext   = S_FAULT;
          codeNext = FC_WRITE;
        end else if (sts.dirStale) begin
          stNext = S_WB_DIR;
        end else if (sts.tblStale) begin
          stNext = S_WB_TBL;
        end else begin
          stNext = S_DONE;
        end
      end
      S_WB_DIR: begin
        stb.wrDir = 1'b1;
        stNext    = sts.tblStale ? S_WB_TBL : S_DONE;
      end
      S_WB_TBL: begin
        stb.wrTbl = 1'b1;
        stNext    = S_DONE;
      end
      S_DONE, S_FAULT: stNext = S_IDLE;
      default:         stNext = S_IDLE;
    endcase
  end

  assign memRdEn   = stb.rdDir | stb.rdTbl;
  assign memWrEn   = stb.wrDir | stb.wrTbl;
  assign done      = (st == S_DONE) || (st == S_FAULT);
  assign fault     = (st == S_FAULT);
  assign faultCode = codeQ;
  assign busy      = (st != S_IDLE);

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: an absent directory entry ends the walk as code 0
  a_r2_absent_dir: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_DIR_WAIT && memRvalid && !sts.rdPresent) |=> (fault && faultCode == 2'd0));

  // R2: the second read is only issued below a present directory entry
  a_r2_tbl_read_needs_dir: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdTbl |-> sts.dirPresent);

  // R3: a privilege refusal surfaces as code 1 on the next cycle
  a_r3_priv_code: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_CHECK && sts.tblPresent && sts.privDeny) |=> (fault && faultCode == 2'd1));

  // R6: write-backs start only once all checks have passed
  a_r6_wb_after_check: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrEn) |-> ($past(st) == S_CHECK));

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter  int IDX_W  = 10,
  localparam int ADDR_W = 3 * IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqPriv,
  input  logic [ADDR_W-1:0] rootBase,
  input  logic              pagingEn,
  input  logic              protEn,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata,
  input  logic              memRvalid,
  output logic              done,
  output logic              fault,
  output logic [1:0]        faultCode,
  output logic              busy
  ,output logic [ADDR_W-1:0] physAddr
);

  walkStb_t stb;
  walkSts_t sts;

  pw_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .pagingEn (pagingEn),
    .protEn   (protEn),
    .memRvalid(memRvalid),
    .sts      (sts),
    .stb      (stb),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn),
    .done     (done),
    .fault    (fault),
    .faultCode(faultCode),
    .busy     (busy)
  );

  pw_datapath #(.IDX_W(IDX_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWrite(reqWrite),
    .reqPriv (reqPriv),
    .pagingEn(pagingEn),
    .rootBase(rootBase),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .physAddr(physAddr),
    .sts     (sts)
  );

  // R8: a mode error never reaches memory
  a_r8_mode_no_traffic: assert property (@(posedge clk) disable iff (!rstN)
    (fault && faultCode == 2'd3) |-> $past(!memRdEn && !memWrEn));

endmodule

// File: tb/test_page_walker.sv
module test_page_walker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, pagingEn, protEn;
  logic [31:0] reqAddr, rootBase;
  logic [1:0]  reqPriv;
  logic        memRdEn, memWrEn, memRvalid;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        done, fault, busy;
  logic [1:0]  faultCode;
  logic [31:0] physAddr;

  int nChecks = 0;
  int nFails  = 0;
  int rdCount = 0;
  int wrCount = 0;
  bit finished = 0;

  logic [31:0] mem [logic [31:0]];

  always #5ns clk = ~clk;

  page_walker i_page_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqPriv(reqPriv), .rootBase(rootBase),
    .pagingEn(pagingEn), .protEn(protEn), .memRdEn(memRdEn),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRvalid(memRvalid), .done(done),
    .fault(fault), .faultCode(faultCode), .busy(busy), .physAddr(physAddr)
  );

  // One-cycle-latency entry memory with access counters
  always @(posedge clk) begin
    memRvalid <= 1'b0;
    if (memRdEn) begin
      rdCount++;
      memRdata  <= mem.exists(memAddr) ? mem[memAddr] : 32'h0;
      memRvalid <= 1'b1;
    end
    if (memWrEn) begin
      wrCount++;
      mem[memAddr] = memWdata;
    end
  end

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runReq(input logic [31:0] lin, input logic wr,
                        input logic [1:0] pr, output bit seen);
    @(negedge clk);
    reqAddr  = lin;
    reqWrite = wr;
    reqPriv  = pr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 50 && !done; n++) @(negedge clk);
    seen = done;
  endtask

  typedef struct packed {
    logic [31:0] lin;
    logic        wr;
    logic [1:0]  priv;
    logic [31:0] dirE;
    logic [31:0] tblE;
    logic        flt;
    logic [1:0]  code;
    logic [31:0] phys;
    logic [31:0] dirAfter;
    logic [31:0] tblAfter;
    logic [3:0]  reads;
    logic [3:0]  writes;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1 R5 worked example, read at privilege 0
    '{32'h00801050, 1'b0, 2'd0, 32'h08001001, 32'h0000C001, 1'b0, 2'd0, 32'h0000C050, 32'h08001021, 32'h0000C021, 4'd2, 4'd2},
    // R4 supervisor write to read-only page; R6 only table written
    '{32'h00801050, 1'b1, 2'd0, 32'h08001021, 32'h0000C021, 1'b0, 2'd0, 32'h0000C050, 32'h08001021, 32'h0000C061, 4'd2, 4'd1},
    // R3 table refuses user
    '{32'h00801050, 1'b0, 2'd3, 32'h08001027, 32'h0000C023, 1'b1, 2'd1, 32'h0, 32'h08001027, 32'h0000C023, 4'd2, 4'd0},
    // R4 directory read-only restricts user write
    '{32'h00801050, 1'b1, 2'd3, 32'h08001025, 32'h0000C027, 1'b1, 2'd2, 32'h0, 32'h08001025, 32'h0000C027, 4'd2, 4'd0},
    // R5 user write: dirty only in table entry
    '{32'h00801050, 1'b1, 2'd3, 32'h08001007, 32'h0000C007, 1'b0, 2'd0, 32'h0000C050, 32'h08001027, 32'h0000C067, 4'd2, 4'd2},
    // R2 absent directory entry: one read
    '{32'h00801050, 1'b0, 2'd0, 32'h08001006, 32'h0000C007, 1'b1, 2'd0, 32'h0, 32'h08001006, 32'h0000C007, 4'd1, 4'd0},
    // R2 absent table entry
    '{32'h00801050, 1'b0, 2'd0, 32'h08001007, 32'h0000C006, 1'b1, 2'd0, 32'h0, 32'h08001007, 32'h0000C006, 4'd2, 4'd0},
    // R3 directory refuses user
    '{32'h00801050, 1'b0, 2'd3, 32'h08001003, 32'h0000C007, 1'b1, 2'd1, 32'h0, 32'h08001003, 32'h0000C007, 4'd2, 4'd0},
    // R1 last directory slot, full offset; R6 nothing to write
    '{32'hFFC00FFF, 1'b1, 2'd2, 32'h12345027, 32'hABCDE067, 1'b0, 2'd0, 32'hABCDEFFF, 32'h12345027, 32'hABCDE067, 4'd2, 4'd0},
    // R6 user write with bits already set: no write-back
    '{32'h00801050, 1'b1, 2'd3, 32'h08001027, 32'h0000C067, 1'b0, 2'd0, 32'h0000C050, 32'h08001027, 32'h0000C067, 4'd2, 4'd0},
    // R6 attribute bits 3 and 4 preserved
    '{32'h00801050, 1'b0, 2'd1, 32'h08001021, 32'h0000C01F, 1'b0, 2'd0, 32'h0000C050, 32'h08001021, 32'h0000C03F, 4'd2, 4'd1},
    // R4 privilege code wins over write code
    '{32'h00801050, 1'b1, 2'd3, 32'h08001001, 32'h0000C007, 1'b1, 2'd1, 32'h0, 32'h08001001, 32'h0000C007, 4'd2, 4'd0}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [31:0] dAddr, tAddr;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqPriv = 2'd0;
    reqAddr = '0; rootBase = 32'h00005000; pagingEn = 1'b1; protEn = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!done && !busy, "R10", "idle outputs", {30'd0, done, busy}, 32'h0);
    chk(!memRdEn && !memWrEn, "R10", "no memory strobes", {30'd0, memRdEn, memWrEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !busy, "R10", "idle after release", {30'd0, done, busy}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      mem.delete();
      dAddr = {rootBase[31:12], VECS[i].lin[31:22], 2'b00};
      tAddr = {VECS[i].dirE[31:12], VECS[i].lin[21:12], 2'b00};
      mem[dAddr] = VECS[i].dirE;
      mem[tAddr] = VECS[i].tblE;
      rdCount = 0;
      wrCount = 0;
      runReq(VECS[i].lin, VECS[i].wr, VECS[i].priv, seen);
      chk(seen, "R9", $sformatf("vec%0d done", i), {31'd0, seen}, 32'h1);
      chk(fault == VECS[i].flt, VECS[i].flt ? "R2/R3/R4" : "R1",
          $sformatf("vec%0d fault", i), {31'd0, fault}, {31'd0, VECS[i].flt});
      if (VECS[i].flt)
        chk(faultCode == VECS[i].code, "R2/R3/R4", $sformatf("vec%0d code", i),
            {30'd0, faultCode}, {30'd0, VECS[i].code});
      else
        chk(physAddr == VECS[i].phys, "R1", $sformatf("vec%0d phys", i), physAddr, VECS[i].phys);
      @(negedge clk);
      chk(!done && !busy, "R9", $sformatf("vec%0d pulse end", i), {30'd0, done, busy}, 32'h0);
      chk(peek(dAddr) == VECS[i].dirAfter, "R5", $sformatf("vec%0d dir entry", i),
          peek(dAddr), VECS[i].dirAfter);
      chk(peek(tAddr) == VECS[i].tblAfter, "R5", $sformatf("vec%0d tbl entry", i),
          peek(tAddr), VECS[i].tblAfter);
      chk(rdCount == int'(VECS[i].reads), "R2", $sformatf("vec%0d reads", i),
          rdCount, {28'd0, VECS[i].reads});
      chk(wrCount == int'(VECS[i].writes), "R6", $sformatf("vec%0d writes", i),
          wrCount, {28'd0, VECS[i].writes});
    end

    // R7 translation off: pass-through, no traffic
    rdCount = 0; wrCount = 0; pagingEn = 1'b0;
    runReq(32'h12345678, 1'b1, 2'd3, seen);
    chk(seen && !fault, "R7", "bypass done", {30'd0, seen, fault}, 32'h2);
    chk(physAddr == 32'h12345678, "R7", "bypass phys", physAddr, 32'h12345678);
    chk(rdCount == 0 && wrCount == 0, "R7", "bypass traffic", rdCount + wrCount, 32'h0);

    // R8 translation on without protection
    rdCount = 0; wrCount = 0; pagingEn = 1'b1; protEn = 1'b0;
    runReq(32'h00801050, 1'b0, 2'd0, seen);
    chk(seen && fault, "R8", "mode fault", {30'd0, seen, fault}, 32'h3);
    chk(faultCode == 2'd3, "R8", "mode code", {30'd0, faultCode}, 32'h3);
    chk(rdCount == 0 && wrCount == 0, "R8", "mode traffic", rdCount + wrCount, 32'h0);
    protEn = 1'b1;

    // R9 busy while a walk is in flight
    mem.delete();
    mem[32'h00005008] = 32'h08001001;
    mem[32'h08001004] = 32'h0000C001;
    @(negedge clk);
    reqAddr = 32'h00801050; reqWrite = 1'b0; reqPriv = 2'd0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy && !done, "R9", "busy during walk", {30'd0, busy, done}, 32'h2);
    for (int n = 0; n < 50 && !done; n++) @(negedge clk);
    chk(done && physAddr == 32'h0000C050, "R9", "walk result", physAddr, 32'h0000C050);

    finished = 1;
    summary();
    $finish;
  end

endmodule